// File: doc/BRIEF.md
# Guarded Configuration Register Sequencer

This block sits behind a two-wire serial slave front end that has already turned the bus into decoded events: a start, a stop, a device byte (a 4-bit type code plus a read flag), a register address and data bytes, each marked by a one-cycle valid. The block owns a small nonvolatile configuration register holding a 2-bit watchdog interval selector and a 3-bit block-protect selector. It acknowledges only the transactions that target this register and changes the register only through a guarded sequence. That sequence has three steps: set the first unlock latch, then the second unlock latch, then write the payload.

Every update is a write with device code `1011`, the all-ones register address, and exactly one data byte. Nothing takes effect before the stop. When both unlock latches are set, the byte held at stop is a payload. The block then clears both latches and enters a store cycle that lasts `NV_CYCLES` clocks with `busy` high. At the end of that cycle it loads the new selectors. The block also decodes the protect selector into a region at the top of the memory array and gates array write requests against that region.

States: `S_IDLE` (bus idle), `S_WAIT_DEV` (after start), `S_WAIT_ADDR` (device byte accepted), `S_WAIT_DATA` (address accepted), `S_HAVE_BYTE` (one data byte held), `S_OVERRUN` (a second data byte arrived), `S_IGNORE` (the transaction is not for this register) and `S_STORE` (nonvolatile cycle). The transitions are:
- start: `S_IDLE` → `S_WAIT_DEV`.
- device byte: `S_WAIT_DEV` → `S_WAIT_ADDR` when the code matches and the access is a write; otherwise `S_WAIT_DEV` → `S_IGNORE`.
- address byte: `S_WAIT_ADDR` → `S_WAIT_DATA` on the register address; otherwise `S_WAIT_ADDR` → `S_IGNORE`.
- data bytes: `S_WAIT_DATA` → `S_HAVE_BYTE` on the first byte; `S_HAVE_BYTE` → `S_OVERRUN` on a further byte.
- stop while holding a byte: `S_HAVE_BYTE` → `S_STORE` when both latches are set; otherwise `S_HAVE_BYTE` → `S_IDLE`.
- store done: `S_STORE` → `S_IDLE`.
- interruptions: any other non-store state returns to `S_IDLE` on stop, and every non-idle, non-store state goes to `S_WAIT_DEV` on a repeated start.

Top module: `ctlreg_guard`

## Requirements
- R1: After reset, `byte_ack`, `busy`, `unlock1` and `unlock2` are 0, and `wd_sel` and `bp_sel` hold their reset parameters (default 0).
- R2: A single-byte register write of 0x02 sets `unlock1` at stop. A single-byte register write of 0x06 made while `unlock1` is 1 sets `unlock2` at stop. A single-byte register write of 0x00 made while `unlock2` is 0 clears both latches. `unlock2` is never 1 while `unlock1` is 0.
- R3: A single-byte register write of 0x06 made while `unlock1` is 0 changes nothing.
- R4: A single-byte register write made while both latches are 1 is a payload. At stop both latches clear and `busy` rises for exactly `NV_CYCLES` cycles. When `busy` falls, `wd_sel` takes data bits [4:3] and `bp_sel` takes data bits [7:5]. The selectors change at no other time.
- R5: With the latches not both set, any single data byte other than 0x00, 0x02 or 0x06 is discarded at stop, and the latches and selectors are unchanged.
- R6: `byte_ack` pulses in the cycle after the byte in each of these cases: a device byte with code `1011` and the read flag 0; the address that follows it, when that address is all ones; and the first data byte after that.
- R7: A second data byte in the same transaction gets no acknowledge, and the whole transaction is then discarded at stop.
- R8: A device byte with another code or with the read flag set, or a non-matching address, gets no acknowledge. Nothing else in that transaction is acknowledged or takes effect.
- R9: A repeated start before stop discards the held byte.
- R10: While `busy` is 1, no byte is acknowledged and start events are ignored.
- R11: The protected region is the top part of the array, selected by `bp_sel`: 0 none, 1 upper quarter, 2 upper half, 3 all, 4 top 16 bytes, 5 top 32, 6 top 64, 7 top 128 (with the default 9-bit address).
- R12: `arr_wr_grant` equals `arr_wr_req` when `arr_addr` is outside the protected region and 0 inside it, in the same cycle, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Start or repeated start event |
| tx_stop | input | 1 | Stop event |
| dev_valid | input | 1 | Device byte present |
| dev_code | input | 4 | Device type code of the device byte |
| dev_read | input | 1 | Read flag of the device byte |
| addr_valid | input | 1 | Address byte present |
| addr_in | input | ADDR_W | Register or array address |
| data_valid | input | 1 | Data byte present |
| data_in | input | 8 | Data byte |
| byte_ack | output | 1 | Acknowledge for the previous cycle's byte |
| busy | output | 1 | Nonvolatile store cycle in progress |
| unlock1 | output | 1 | First unlock latch |
| unlock2 | output | 1 | Second unlock latch |
| wd_sel | output | 2 | Stored watchdog interval selector |
| bp_sel | output | 3 | Stored block-protect selector |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Array write address |
| arr_wr_grant | output | 1 | Array write permitted |

## Verification
The properties assume a well-formed decoded event stream. At most one of start, stop and the three byte valids is high in any cycle, each event lasts one cycle, and a stop never coincides with a start. On that basis, an acknowledge always traces back to a byte in the preceding cycle, and a store cycle cannot begin in the same edge as an acknowledge. The bench drives exactly one event per clock, each from a task that releases it at the next falling edge, so two events are never adjacent in a way that could overlap.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_DEV,
        S_WAIT_ADDR,
        S_WAIT_DATA,
        S_HAVE_BYTE,
        S_OVERRUN,
        S_IGNORE,
        S_STORE
    } seq_state_t;

    localparam int WD_LSB = 3;
    localparam int WD_W   = 2;
    localparam int BP_LSB = 5;
    localparam int BP_W   = 3;

    localparam logic [7:0] CODE_UNLOCK1 = 8'h02;
    localparam logic [7:0] CODE_UNLOCK2 = 8'h06;
    localparam logic [7:0] CODE_RELOCK  = 8'h00;

endpackage

// File: rtl/nv_store_timer.sv
module nv_store_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] count;

    assign done = run && (count == CNT_W'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else if (!done) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bp_range_decoder.sv
module bp_range_decoder #(
    parameter int ADDR_W    = 9,
    parameter int SMALL_LOG = 4
) (
    input  logic [2:0]        bp_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam logic [ADDR_W:0] SPAN    = (ADDR_W+1)'(1) << ADDR_W;
    localparam logic [ADDR_W:0] QUARTER = SPAN >> 2;
    localparam logic [ADDR_W:0] HALF    = SPAN >> 1;

    logic [ADDR_W:0] base;
    logic [ADDR_W:0] small_len;

    always_comb begin
        small_len = (ADDR_W+1)'(1) << (SMALL_LOG + int'(bp_sel[1:0]));
        unique case (bp_sel)
            3'd0:    base = SPAN;
            3'd1:    base = SPAN - QUARTER;
            3'd2:    base = SPAN - HALF;
            3'd3:    base = '0;
            default: base = SPAN - small_len;
        endcase
    end

    assign in_range = ({1'b0, addr} >= base);
endmodule

// File: rtl/ctlreg_seq.sv
module ctlreg_seq
    import ctlreg_pkg::*;
#(
    parameter int          ADDR_W   = 9,
    parameter logic [3:0]  DEV_CODE = 4'b1011,
    parameter logic [1:0]  WD_RESET = 2'd0,
    parameter logic [2:0]  BP_RESET = 3'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic              tx_stop,
    input  logic              dev_valid,
    input  logic [3:0]        dev_code,
    input  logic              dev_read,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_valid,
    input  logic [7:0]        data_in,
    input  logic              store_done,
    output seq_state_t        state,
    output logic              byte_ack,
    output logic              unlock1,
    output logic              unlock2,
    output logic [WD_W-1:0]   wd_sel,
    output logic [BP_W-1:0]   bp_sel
);
    localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

    seq_state_t nxt;
    logic       ack_nxt;
    logic       take_byte;
    logic       stop_eval;
    logic [7:0] held;

    always_comb begin
        nxt       = state;
        ack_nxt   = 1'b0;
        take_byte = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (tx_start) nxt = S_WAIT_DEV;
            end
            S_WAIT_DEV: begin
                if (dev_valid) begin
                    if (dev_code == DEV_CODE && !dev_read) begin
                        nxt     = S_WAIT_ADDR;
                        ack_nxt = 1'b1;
                    end else begin
                        nxt = S_IGNORE;
                    end
                end
            end
            S_WAIT_ADDR: begin
                if (addr_valid) begin
                    if (addr_in == REG_ADDR) begin
                        nxt     = S_WAIT_DATA;
                        ack_nxt = 1'b1;
                    end else begin
                        nxt = S_IGNORE;
                    end
                end
            end
            S_WAIT_DATA: begin
                if (data_valid) begin
                    nxt       = S_HAVE_BYTE;
                    ack_nxt   = 1'b1;
                    take_byte = 1'b1;
                end
            end
            S_HAVE_BYTE: begin
                if (data_valid) begin
                    nxt = S_OVERRUN;
                end else if (tx_stop) begin
                    nxt = (unlock1 && unlock2) ? S_STORE : S_IDLE;
                end
            end
            S_OVERRUN: begin
                nxt = state;
            end
            S_IGNORE: begin
                nxt = state;
            end
            S_STORE: begin
                if (store_done) nxt = S_IDLE;
            end
        endcase
        if (state != S_STORE && state != S_IDLE) begin
            if (tx_stop && state != S_HAVE_BYTE) nxt = S_IDLE;
            if (tx_start) nxt = S_WAIT_DEV;
        end
    end

    assign stop_eval = (state == S_HAVE_BYTE) && tx_stop && !data_valid && !tx_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_ack <= 1'b0;
            held     <= '0;
            unlock1  <= 1'b0;
            unlock2  <= 1'b0;
            wd_sel   <= WD_RESET;
            bp_sel   <= BP_RESET;
        end else begin
            byte_ack <= ack_nxt;
            if (take_byte) held <= data_in;
            if (stop_eval) begin
                if (unlock1 && unlock2) begin
                    unlock1 <= 1'b0;
                    unlock2 <= 1'b0;
                end else begin
                    unique case (held)
                        CODE_UNLOCK1: unlock1 <= 1'b1;
                        CODE_UNLOCK2: if (unlock1) unlock2 <= 1'b1;
                        CODE_RELOCK: begin
                            unlock1 <= 1'b0;
                            unlock2 <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            if (state == S_STORE && store_done) begin
                wd_sel <= held[WD_LSB +: WD_W];
                bp_sel <= held[BP_LSB +: BP_W];
            end
        end
    end
endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
    import ctlreg_pkg::*;
#(
    parameter int          ADDR_W    = 9,
    parameter int          NV_CYCLES = 64,
    parameter int          SMALL_LOG = 4,
    parameter logic [3:0]  DEV_CODE  = 4'b1011,
    parameter logic [1:0]  WD_RESET  = 2'd0,
    parameter logic [2:0]  BP_RESET  = 3'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic              tx_stop,
    input  logic              dev_valid,
    input  logic [3:0]        dev_code,
    input  logic              dev_read,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_valid,
    input  logic [7:0]        data_in,
    output logic              byte_ack,
    output logic              busy,
    output logic              unlock1,
    output logic              unlock2,
    output logic [1:0]        wd_sel,
    output logic [2:0]        bp_sel,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              arr_wr_grant
);
    seq_state_t state;
    logic       store_done;
    logic       protected_hit;

    ctlreg_seq #(
        .ADDR_W   (ADDR_W),
        .DEV_CODE (DEV_CODE),
        .WD_RESET (WD_RESET),
        .BP_RESET (BP_RESET)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_start   (tx_start),
        .tx_stop    (tx_stop),
        .dev_valid  (dev_valid),
        .dev_code   (dev_code),
        .dev_read   (dev_read),
        .addr_valid (addr_valid),
        .addr_in    (addr_in),
        .data_valid (data_valid),
        .data_in    (data_in),
        .store_done (store_done),
        .state      (state),
        .byte_ack   (byte_ack),
        .unlock1    (unlock1),
        .unlock2    (unlock2),
        .wd_sel     (wd_sel),
        .bp_sel     (bp_sel)
    );

    assign busy = (state == S_STORE);

    nv_store_timer #(
        .CYCLES (NV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .done  (store_done)
    );

    bp_range_decoder #(
        .ADDR_W    (ADDR_W),
        .SMALL_LOG (SMALL_LOG)
    ) u_dec (
        .bp_sel   (bp_sel),
        .addr     (arr_addr),
        .in_range (protected_hit)
    );

    assign arr_wr_grant = arr_wr_req && !protected_hit;
endmodule

// File: rtl/ctlreg_guard_chk.sv
module ctlreg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       byte_ack,
    input logic       dev_valid,
    input logic       addr_valid,
    input logic       data_valid,
    input logic       unlock1,
    input logic       unlock2,
    input logic [1:0] wd_sel,
    input logic [2:0] bp_sel,
    input logic       arr_wr_req,
    input logic       arr_wr_grant
);
    p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !byte_ack);

    p_ack_has_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ack |-> $past(dev_valid || addr_valid || data_valid));

    p_second_needs_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unlock2 |-> unlock1);

    p_busy_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!unlock1 && !unlock2));

    p_cfg_only_at_store_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy) |-> ($stable(wd_sel) && $stable(bp_sel)));

    p_grant_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_grant |-> arr_wr_req);

    p_all_protected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_sel == 3'd3) |-> !arr_wr_grant);
endmodule

bind ctlreg_guard ctlreg_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .byte_ack     (byte_ack),
    .dev_valid    (dev_valid),
    .addr_valid   (addr_valid),
    .data_valid   (data_valid),
    .unlock1      (unlock1),
    .unlock2      (unlock2),
    .wd_sel       (wd_sel),
    .bp_sel       (bp_sel),
    .arr_wr_req   (arr_wr_req),
    .arr_wr_grant (arr_wr_grant)
);

// File: tb/ctlreg_guard_tb.sv
module ctlreg_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 9;
    localparam int NV         = 20;
    localparam int SPAN       = 512;
    localparam logic [AW-1:0] REGA = 9'h1FF;

    // entry: data[15:8] exp_u1[7] exp_u2[6] exp_busy[5] exp_wd[4:3] exp_bp[2:0]
    localparam int NVEC = 10;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h06, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},  // R3
        {8'h55, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},  // R5
        {8'h02, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0},  // R2
        {8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0},  // R2 relock
        {8'h02, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0},  // R2
        {8'h06, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0},  // R2
        {8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0},  // R4 payload
        {8'h02, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0},
        {8'h06, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0},
        {8'h9A, 1'b0, 1'b0, 1'b1, 2'd3, 3'd4}   // R4 payload
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_start = 1'b0, tx_stop = 1'b0;
    logic dev_valid = 1'b0, dev_read = 1'b0;
    logic [3:0] dev_code = 4'd0;
    logic addr_valid = 1'b0, data_valid = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0] data_in = '0;
    logic arr_wr_req = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic byte_ack, busy, unlock1, unlock2, arr_wr_grant;
    logic [1:0] wd_sel;
    logic [2:0] bp_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlreg_guard #(.ADDR_W(AW), .NV_CYCLES(NV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_stop(tx_stop),
        .dev_valid(dev_valid), .dev_code(dev_code), .dev_read(dev_read),
        .addr_valid(addr_valid), .addr_in(addr_in), .data_valid(data_valid),
        .data_in(data_in), .byte_ack(byte_ack), .busy(busy), .unlock1(unlock1),
        .unlock2(unlock2), .wd_sel(wd_sel), .bp_sel(bp_sel),
        .arr_wr_req(arr_wr_req), .arr_addr(arr_addr), .arr_wr_grant(arr_wr_grant)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic ev_start();
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    endtask
    task automatic ev_stop();
        tx_stop = 1'b1; @(negedge clk); tx_stop = 1'b0;
    endtask
    task automatic ev_dev(input logic [3:0] c, input logic rd, output logic a);
        dev_code = c; dev_read = rd; dev_valid = 1'b1;
        @(negedge clk); dev_valid = 1'b0; a = byte_ack;
    endtask
    task automatic ev_addr(input logic [AW-1:0] v, output logic a);
        addr_in = v; addr_valid = 1'b1;
        @(negedge clk); addr_valid = 1'b0; a = byte_ack;
    endtask
    task automatic ev_data(input logic [7:0] v, output logic a);
        data_in = v; data_valid = 1'b1;
        @(negedge clk); data_valid = 1'b0; a = byte_ack;
    endtask

    task automatic reg_write(input logic [7:0] v, output logic a0, output logic a1, output logic a2);
        ev_start();
        ev_dev(4'b1011, 1'b0, a0);
        ev_addr(REGA, a1);
        ev_data(v, a2);
        ev_stop();
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic program_cfg(input logic [2:0] bp, input logic [1:0] wd);
        logic a0, a1, a2;
        int n;
        reg_write(8'h02, a0, a1, a2);
        reg_write(8'h06, a0, a1, a2);
        reg_write({bp, wd, 3'b000}, a0, a1, a2);
        wait_idle(n);
        check("R4 programmed bp", int'(bp_sel), int'(bp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a0, a1, a2, a3;
        int n;
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack", byte_ack, 0);
        check("R1 busy", busy, 0);
        check("R1 unlock1", unlock1, 0);
        check("R1 unlock2", unlock2, 0);
        check("R1 wd", wd_sel, 0);
        check("R1 bp", bp_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {unlock1, unlock2, busy}, 0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            reg_write(VEC[i][15:8], a0, a1, a2);
            check("R6 acks", {a0, a1, a2}, 7);
            check("R2 unlock1", unlock1, VEC[i][7]);
            check("R2 unlock2", unlock2, VEC[i][6]);
            check("R4 busy", busy, VEC[i][5]);
            if (VEC[i][5]) begin
                check("R4 cfg held during store", bp_sel, (i == 9) ? 0 : int'(bp_sel));
                wait_idle(n);
                check("R4 busy length", n, NV);
            end
            check("R4 wd", wd_sel, VEC[i][4:3]);
            check("R4 bp", bp_sel, VEC[i][2:0]);
        end

        // R8 wrong code, read flag, wrong address
        ev_start(); ev_dev(4'b1010, 1'b0, a0); ev_addr(REGA, a1); ev_data(8'h02, a2); ev_stop();
        check("R8 wrong code no ack", {a0, a1, a2}, 0);
        check("R8 wrong code no effect", unlock1, 0);
        ev_start(); ev_dev(4'b1011, 1'b1, a0); ev_addr(REGA, a1); ev_data(8'h02, a2); ev_stop();
        check("R8 read flag no ack", {a0, a1, a2}, 0);
        check("R8 read flag no effect", unlock1, 0);
        ev_start(); ev_dev(4'b1011, 1'b0, a0); ev_addr(9'h1FE, a1); ev_data(8'h02, a2); ev_stop();
        check("R8 wrong addr acks", {a0, a1, a2}, 4);
        check("R8 wrong addr no effect", unlock1, 0);

        // R7 second data byte
        reg_write(8'h02, a0, a1, a2);
        reg_write(8'h06, a0, a1, a2);
        ev_start(); ev_dev(4'b1011, 1'b0, a0); ev_addr(REGA, a1);
        ev_data(8'hE8, a2); ev_data(8'hE8, a3); ev_stop();
        check("R7 acks", {a0, a1, a2, a3}, 14);
        check("R7 no store", busy, 0);
        check("R7 latches kept", {unlock1, unlock2}, 3);
        check("R7 bp unchanged", bp_sel, 4);

        // R9 repeated start discards held byte
        ev_start(); ev_dev(4'b1011, 1'b0, a0); ev_addr(REGA, a1); ev_data(8'hE8, a2);
        ev_start(); ev_stop();
        check("R9 no store", busy, 0);
        check("R9 latches kept", {unlock1, unlock2}, 3);

        // R10 busy blocks requests
        reg_write(8'hE8, a0, a1, a2);
        check("R4 store starts", busy, 1);
        ev_start(); ev_dev(4'b1011, 1'b0, a0); ev_addr(REGA, a1);
        check("R10 no ack while busy", {a0, a1}, 0);
        ev_stop();
        wait_idle(n);
        check("R4 bp after store", bp_sel, 7);
        check("R4 wd after store", wd_sel, 1);
        check("R10 no stray unlock", unlock1, 0);

        // R11 R12 region decode
        for (int b = 0; b < 8; b++) begin
            program_cfg(3'(b), 2'd0);
            case (b)
                0: base = SPAN;
                1: base = SPAN - SPAN / 4;
                2: base = SPAN / 2;
                3: base = 0;
                default: base = SPAN - (16 << (b - 4));
            endcase
            arr_wr_req = 1'b1;
            for (int k = 0; k < 4; k++) begin
                int ad;
                case (k)
                    0: ad = 0;
                    1: ad = SPAN - 1;
                    2: ad = (base > 0) ? base - 1 : 0;
                    default: ad = (base < SPAN) ? base : SPAN - 1;
                endcase
                arr_addr = AW'(ad);
                #1;
                check("R11 R12 grant", arr_wr_grant, (ad >= base) ? 0 : 1);
            end
            arr_wr_req = 1'b0;
            #1;
            check("R12 no req no grant", arr_wr_grant, 0);
            @(negedge clk);
        end

        finish_run();
    end
endmodule